// File: doc/BRIEF.md
# Clock Generator Lock and Limp-Home Status Register

This block is the single 8-bit status register that a clock generator exposes to software. It watches two raw indications from elsewhere in the clock generator: a lock signal from the frequency lock detector and a limp-home signal from the reference-loss monitor. Both pass through a synchronizer into the register's clock domain. Software reads them as read-only status bits.

For each status bit, the register keeps a sticky change flag. The flag records any toggle of its status bit, in either direction. Software clears a flag by writing one to its bit position. Because the lock detector cannot work without a reference clock, the lock status and the lock-change flag are forced to zero while limp-home is active. Each flag has its own enable input, and the enabled flags are combined into one interrupt request.

Top module: `pll_status_flags`

## Requirements
- R1: After reset, every register bit reads zero and `irq` is low.
- R2: The read word places the lock-change flag at bit 7, the lock status at bit 6, the limp-change flag at bit 1 and the limp status at bit 0. Bits 5 to 2 always read zero. `busRdata` is all zero while `busSel` is low.
- R3: While limp-home is inactive, the lock status bit equals `lockRaw` as it was two rising clock edges earlier (two-flop synchronizer). Writes never alter it.
- R4: The limp status bit equals `limpRaw` as it was two rising clock edges earlier. Writes never alter it.
- R5: While the synchronized limp status is one, the lock status bit reads zero whatever `lockRaw` is.
- R6: The lock-change flag sets one clock edge after the synchronized lock value toggles, for rising and falling toggles alike. It stays set until cleared.
- R7: The limp-change flag sets one clock edge after the synchronized limp value toggles, on entry to limp-home and on exit from it.
- R8: A write (`busSel` and `busWr` high) with bit 7 set clears the lock-change flag. A write with bit 1 set clears the limp-change flag. A zero in either position leaves that flag unchanged.
- R9: While the synchronized limp status is one, the lock-change flag is held at zero. This includes a lock toggle in the same cycle that limp-home becomes active.
- R10: When a flag's set event and a clearing write land on the same clock edge, the flag ends up set.
- R11: `irq` equals (lock-change flag AND `lockIrqEn`) OR (limp-change flag AND `limpIrqEn`), with no added delay from the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Register selected by the bus |
| busWr | input | 1 | Write strobe, valid with busSel |
| busWdata | input | 8 | Write data; a one clears the matching flag |
| busRdata | output | 8 | Read data |
| lockRaw | input | 1 | Unsynchronized lock indication |
| limpRaw | input | 1 | Unsynchronized reference-lost indication |
| lockIrqEn | input | 1 | Interrupt enable for the lock-change flag |
| limpIrqEn | input | 1 | Interrupt enable for the limp-change flag |
| irq | output | 1 | Interrupt request |

## Verification
Several properties are checked on every clock. The lock flag stays clear in the cycle after limp-home. Reserved bits stay zero. Lock status is masked during limp-home. A detected toggle always leaves its flag set, and a clear with no competing set always empties the flag.

Other behaviour can only be shown by the bench's scenarios. These are the end-to-end latency from a raw input through the synchronizer, the cycle-exact collision between a set event and a clearing write, and the irq gating under every combination of enables. The bench drives random sequences of input toggles and writes against a settled-state model, and adds directed cases for the collision and the limp entry edge.

// File: rtl/pll_status_pkg.sv
package pll_status_pkg;
  localparam int DATA_W        = 8;
  localparam int LOCK_FLAG_BIT = 7;
  localparam int LOCK_STAT_BIT = 6;
  localparam int LIMP_FLAG_BIT = 1;
  localparam int LIMP_STAT_BIT = 0;

  typedef struct packed {
    logic lockNow;
    logic limpNow;
    logic lockChg;
    logic limpChg;
    logic clrLock;
    logic clrLimp;
  } ctlStrobes_t;
endpackage

// File: rtl/pll_status_ctrl.sv
module pll_status_ctrl
  import pll_status_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              lockRaw,
  input  logic              limpRaw,
  output ctlStrobes_t       strobes
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] lockPipe, limpPipe;
  logic lockPrev, limpPrev;
  logic lockSync, limpSync;

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          lockPipe <= '0;
          limpPipe <= '0;
        end else begin
          lockPipe <= {lockPipe[SYNC_STAGES-2:0], lockRaw};
          limpPipe <= {limpPipe[SYNC_STAGES-2:0], limpRaw};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          lockPipe <= '0;
          limpPipe <= '0;
        end else begin
          lockPipe <= lockRaw;
          limpPipe <= limpRaw;
        end
      end
    end
  endgenerate

  assign lockSync = lockPipe[LAST];
  assign limpSync = limpPipe[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockPrev <= 1'b0;
      limpPrev <= 1'b0;
    end else begin
      lockPrev <= lockSync;
      limpPrev <= limpSync;
    end
  end

  logic wrStrobe;
  assign wrStrobe = busSel & busWr;

  always_comb begin
    strobes.lockNow = lockSync;
    strobes.limpNow = limpSync;
    strobes.lockChg = lockSync ^ lockPrev;
    strobes.limpChg = limpSync ^ limpPrev;
    strobes.clrLock = wrStrobe & busWdata[LOCK_FLAG_BIT];
    strobes.clrLimp = wrStrobe & busWdata[LIMP_FLAG_BIT];
  end

  // A toggle of the synchronized limp value is visible as a change strobe (R7)
  assert_limp_toggle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (limpSync != $past(limpSync)) |-> strobes.limpChg);
endmodule

// File: rtl/pll_status_dp.sv
module pll_status_dp
  import pll_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  ctlStrobes_t       strobes,
  input  logic              lockIrqEn,
  input  logic              limpIrqEn,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);
  logic lockFlag, limpFlag;
  logic lockStat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockFlag <= 1'b0;
    end else if (strobes.limpNow) begin
      lockFlag <= 1'b0;
    end else if (strobes.lockChg) begin
      lockFlag <= 1'b1;
    end else if (strobes.clrLock) begin
      lockFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limpFlag <= 1'b0;
    end else if (strobes.limpChg) begin
      limpFlag <= 1'b1;
    end else if (strobes.clrLimp) begin
      limpFlag <= 1'b0;
    end
  end

  assign lockStat = strobes.lockNow & ~strobes.limpNow;

  always_comb begin
    busRdata = '0;
    if (busSel) begin
      busRdata[LOCK_FLAG_BIT] = lockFlag;
      busRdata[LOCK_STAT_BIT] = lockStat;
      busRdata[LIMP_FLAG_BIT] = limpFlag;
      busRdata[LIMP_STAT_BIT] = strobes.limpNow;
    end
  end

  assign irq = (lockFlag & lockIrqEn) | (limpFlag & limpIrqEn);

  assert_lock_flag_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.limpNow |=> !lockFlag);

  assert_lock_masked_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && strobes.limpNow) |-> !busRdata[LOCK_STAT_BIT]);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[5:2] == 4'b0000);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.limpChg |=> limpFlag);

  assert_lock_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.lockChg && !strobes.limpNow) |=> lockFlag);

  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrLimp && !strobes.limpChg) |=> !limpFlag);
endmodule

// File: rtl/pll_status_flags.sv
module pll_status_flags
  import pll_status_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              lockRaw,
  input  logic              limpRaw,
  input  logic              lockIrqEn,
  input  logic              limpIrqEn,
  output logic              irq
);
  ctlStrobes_t strobes;

  pll_status_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busWdata(busWdata), .lockRaw(lockRaw), .limpRaw(limpRaw),
    .strobes(strobes)
  );

  pll_status_dp i_dp (
    .clk(clk), .rstN(rstN), .busSel(busSel), .strobes(strobes),
    .lockIrqEn(lockIrqEn), .limpIrqEn(limpIrqEn),
    .busRdata(busRdata), .irq(irq)
  );
endmodule

// File: tb/test_pll_status_flags.sv
module test_pll_status_flags;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b1;
  logic busWr = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic lockRaw = 1'b0, limpRaw = 1'b0;
  logic lockIrqEn = 1'b0, limpIrqEn = 1'b0;
  logic irq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // Reference state, settled view
  logic mLock = 0, mLimp = 0, mLockFlag = 0, mLimpFlag = 0;

  always #2 clk = ~clk;

  pll_status_flags i_pll_status_flags (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .lockRaw(lockRaw),
    .limpRaw(limpRaw), .lockIrqEn(lockIrqEn), .limpIrqEn(limpIrqEn),
    .irq(irq)
  );

  function automatic logic [7:0] expWord();
    return {mLockFlag, mLock & ~mLimp, 4'b0000, mLimpFlag, mLimp};
  endfunction

  function automatic logic expIrq();
    return (mLockFlag & lockIrqEn) | (mLimpFlag & limpIrqEn);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic busWrite(input logic [7:0] d);
    busWr = 1'b1; busWdata = d;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  // Apply new raw inputs, let them settle, update the model
  task automatic applyInputs(input logic lk, input logic lp);
    logic chgLock, chgLimp;
    chgLock = (lk != mLock);
    chgLimp = (lp != mLimp);
    lockRaw = lk; limpRaw = lp;
    cycles(4);
    mLock = lk; mLimp = lp;
    if (chgLimp) mLimpFlag = 1'b1;
    if (lp) mLockFlag = 1'b0;
    else if (chgLock) mLockFlag = 1'b1;
  endtask

  task automatic modelWrite(input logic [7:0] d);
    busWrite(d);
    if (d[7]) mLockFlag = 1'b0;
    if (d[1]) mLimpFlag = 1'b0;
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    cycles(2);
    // R1: reset state
    check("R1 reset word", busRdata, 8'h00);
    check("R1 reset irq", {7'b0, irq}, 8'h00);
    rstN = 1'b1;
    cycles(2);

    // R3/R6: latency of status (2 edges) and flag (3 edges)
    lockRaw = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R3 lock status after two edges", busRdata, 8'h40);
    @(negedge clk);
    check("R6 lock flag rising toggle", busRdata, 8'hC0);
    mLock = 1; mLockFlag = 1;
    // R3: write cannot alter the status bit; zero in bit 7 keeps flag
    modelWrite(8'h40);
    check("R3 R8 write zero keeps flag, status unchanged", busRdata, expWord());
    modelWrite(8'h80);
    check("R8 clear lock flag", busRdata, 8'h40);
    // R6: falling toggle
    applyInputs(1'b0, 1'b0);
    check("R6 lock flag falling toggle", busRdata, 8'h80);
    modelWrite(8'h80);

    // R10: set event and clear on the same edge
    lockRaw = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    busWr = 1'b1; busWdata = 8'h80;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
    check("R10 set beats clear", busRdata, 8'hC0);
    mLock = 1; mLockFlag = 1;

    // R4/R5/R7/R9: limp entry while lock toggles in the same cycle
    lockRaw = 1'b0; limpRaw = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R4 limp status after two edges", busRdata[0], 1'b1);
    @(negedge clk);
    check("R9 lock flag held at limp entry", busRdata, 8'h03);
    mLock = 0; mLimp = 1; mLockFlag = 0; mLimpFlag = 1;
    lockRaw = 1'b1;
    cycles(4); mLock = 1;
    check("R5 lock status masked in limp", busRdata, 8'h03);
    modelWrite(8'h02);
    check("R8 clear limp flag", busRdata, 8'h01);
    modelWrite(8'hFF);
    check("R4 write cannot alter limp status", busRdata, 8'h01);
    applyInputs(1'b1, 1'b0);
    check("R7 limp flag on exit", busRdata, expWord());

    // R2: read gated by select
    busSel = 1'b0;
    @(negedge clk);
    check("R2 read zero when deselected", busRdata, 8'h00);
    busSel = 1'b1;

    // R11: enable combinations
    for (int e = 0; e < 4; e++) begin
      lockIrqEn = e[0]; limpIrqEn = e[1];
      #1;
      check("R11 irq gating", {7'b0, irq}, {7'b0, expIrq()});
    end

    // Random mix
    for (int it = 0; it < 300; it++) begin
      logic [7:0] w;
      applyInputs(1'($urandom % 2), ($urandom % 4) == 0);
      check("R2 R3 R5 R6 R7 R9 random status", busRdata, expWord());
      w = 8'($urandom);
      if ($urandom % 2) modelWrite(w);
      check("R8 random write", busRdata, expWord());
      lockIrqEn = 1'($urandom % 2); limpIrqEn = 1'($urandom % 2);
      #1;
      check("R11 random irq", {7'b0, irq}, {7'b0, expIrq()});
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule